// File: doc/BRIEF.md
# Burst Read Slave

This block is a read-only slave that answers burst read requests out of a word array held inside the block. A requester places a start byte address and a beat count on the request channel. The block serves each request with the requested number of data beats on the response channel. Both channels use valid/ready flow control, and a transfer takes place on a rising clock edge only when valid and ready are both high in that cycle.

In idle the request ready is high, so a request is taken in the cycle it is presented. Ready then falls for the whole burst. The first beat appears in the cycle after acceptance. Each beat is held until the requester takes it. The final beat is marked with a last flag. In the cycle after the final beat is taken, request ready is high again. Every output comes straight from a register or from a fixed function of a registered index, so no input reaches an output through logic alone.

The array contents come from a fixed formula, so a reader can predict every word. The address width, beat-count width, data width and array depth are parameters.

Top module: `axrd_slave`

## Requirements
- R1: While no burst is in progress, `ar_ready` is high. This includes the first cycle after reset, so a request presented while idle is accepted on the next rising edge.
- R2: `r_valid` rises only in the cycle after a request is accepted (`ar_valid` and `ar_ready` both high at an edge). It is never high at any other time.
- R3: While `r_valid` is high and `r_ready` is low, `r_valid`, `r_data` and `r_last` stay unchanged in the next cycle (back-pressure holds the beat).
- R4: A request with length field `ar_len` = L returns exactly L+1 beats. Beat n carries array word ((`ar_addr` >> 2) + n) mod DEPTH, with 4-byte words and default DEPTH 64, so the index wraps from 63 to 0. Word k holds the low DATA_W bits of (k * 32'h9E3779B1) XOR 32'hA5C30F1E.
- R5: `r_last` is high on the final beat of each burst and low on every other beat.
- R6: `ar_ready` is low while a burst is in progress, and a request presented then has no effect. `ar_ready` returns high, with `r_valid` low, in the cycle after the final beat is taken.
- R7: `r_resp` reads 2'b00 (OKAY) on every beat.
- R8: An active-low `rst_n` abandons any burst in progress. While reset is held, and after it is released, `r_valid` is low and `ar_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ar_valid | input | 1 | Request present |
| ar_ready | output | 1 | Block can take a request |
| ar_addr | input | ADDR_W | Start byte address |
| ar_len | input | LEN_W | Beats minus one |
| r_valid | output | 1 | Data beat present |
| r_ready | input | 1 | Requester takes the beat |
| r_data | output | DATA_W | Beat data |
| r_resp | output | 2 | Status, always OKAY (2'b00) |
| r_last | output | 1 | Final beat of the burst |

## Verification
The hardest case to reach is a stall on the final beat while a new request is already waiting. The block must then hold the last flag without accepting the waiting request. It must accept that request only in the cycle after the final beat is taken. The stimulus drives random `ar_valid` noise throughout every burst and withholds `r_ready` at random, including on last beats. It then issues the next request back to back with no idle cycle, and directed bursts cover the index wrap at the top of the array and a reset in the middle of a burst.

// File: rtl/axrd_pkg.sv
package axrd_pkg;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // Fixed array contents: word k of the store.
  function automatic logic [31:0] fill_word(input int unsigned k);
    logic [31:0] prod;
    prod = k * 32'h9E3779B1;
    return prod ^ 32'hA5C30F1E;
  endfunction

endpackage

// File: rtl/axrd_store.sv
module axrd_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  import axrd_pkg::*;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign words[g] = DATA_W'(fill_word(g));
  end

  always_comb begin
    rd_data = '0;
    if (32'(rd_idx) < DEPTH) rd_data = words[rd_idx];
  end

endmodule

// File: rtl/axrd_burst_ctl.sv
module axrd_burst_ctl #(
  parameter int ADDR_W  = 10,
  parameter int LEN_W   = 4,
  parameter int BYTE_SH = 2,
  parameter int DEPTH   = 64,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WADR_W = ADDR_W - BYTE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic              r_ready,
  output logic              ar_ready,
  output logic              r_valid,
  output logic              r_last,
  output logic [IDX_W-1:0]  cur_idx
);

  logic              busy_q;
  logic [LEN_W-1:0]  left_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WADR_W-1:0] word_addr;
  logic [IDX_W-1:0]  start_idx;
  logic [IDX_W-1:0]  next_idx;
  logic              take_req;
  logic              take_beat;

  assign word_addr = ar_addr[ADDR_W-1:BYTE_SH];
  assign start_idx = IDX_W'(32'(word_addr) % DEPTH);
  assign next_idx  = (32'(idx_q) == DEPTH - 1) ? '0 : idx_q + 1'b1;
  assign take_req  = ar_valid && !busy_q;
  assign take_beat = busy_q && r_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      idx_q  <= '0;
    end else if (take_req) begin
      busy_q <= 1'b1;
      left_q <= ar_len;
      idx_q  <= start_idx;
    end else if (take_beat) begin
      if (left_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
        idx_q  <= next_idx;
      end
    end
  end

  assign ar_ready = !busy_q;
  assign r_valid  = busy_q;
  assign r_last   = busy_q && (left_q == '0);
  assign cur_idx  = idx_q;

endmodule

// File: rtl/axrd_slave.sv
module axrd_slave #(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]  ar_len,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last
);
  import axrd_pkg::*;

  localparam int BYTE_SH = $clog2(DATA_W / 8);
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0] cur_idx;

  axrd_burst_ctl #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .BYTE_SH(BYTE_SH),
    .DEPTH  (DEPTH)
  ) ctl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ar_valid(ar_valid),
    .ar_addr (ar_addr),
    .ar_len  (ar_len),
    .r_ready (r_ready),
    .ar_ready(ar_ready),
    .r_valid (r_valid),
    .r_last  (r_last),
    .cur_idx (cur_idx)
  );

  axrd_store #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) store_i (
    .rd_idx (cur_idx),
    .rd_data(r_data)
  );

  assign r_resp = RESP_OKAY;

endmodule

// File: rtl/axrd_slave_chk.sv
module axrd_slave_chk #(
  parameter int LEN_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [LEN_W-1:0]  ar_len,
  input logic              r_valid,
  input logic              r_ready,
  input logic [DATA_W-1:0] r_data,
  input logic [1:0]        r_resp,
  input logic              r_last
);

  logic [LEN_W-1:0] want_len;
  logic [LEN_W:0]   seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_len <= '0;
      seen     <= '0;
    end else if (ar_valid && ar_ready) begin
      want_len <= ar_len;
      seen     <= '0;
    end else if (r_valid && r_ready) begin
      seen <= seen + 1'b1;
    end
  end

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !r_valid |-> ar_ready);

  p_start_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_valid) |-> $past(ar_valid && ar_ready));

  p_accept_gives_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |=> r_valid);

  p_hold_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_last)));

  p_last_place_r5: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> (r_last == (seen == {1'b0, want_len})));

  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> !ar_ready);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_ready && r_last) |=> (ar_ready && !r_valid));

  p_okay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> (r_resp == 2'b00));

endmodule

bind axrd_slave axrd_slave_chk #(.LEN_W(LEN_W), .DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ar_valid(ar_valid),
  .ar_ready(ar_ready),
  .ar_len  (ar_len),
  .r_valid (r_valid),
  .r_ready (r_ready),
  .r_data  (r_data),
  .r_resp  (r_resp),
  .r_last  (r_last)
);

// File: tb/axrd_slave_tb_top.sv
module axrd_slave_tb_top;

  localparam int ADDR_W = 10;
  localparam int LEN_W  = 4;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ar_valid = 1'b0;
  logic              ar_ready;
  logic [ADDR_W-1:0] ar_addr = '0;
  logic [LEN_W-1:0]  ar_len = '0;
  logic              r_valid;
  logic              r_ready = 1'b0;
  logic [DATA_W-1:0] r_data;
  logic [1:0]        r_resp;
  logic              r_last;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  axrd_slave #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
    .r_last(r_last)
  );

  function automatic logic [DATA_W-1:0] exp_word(input int unsigned k);
    logic [31:0] p;
    p = k * 32'h9E3779B1;
    return DATA_W'(p ^ 32'hA5C30F1E);
  endfunction

  function automatic int unsigned exp_idx(input logic [ADDR_W-1:0] a, input int n);
    return ((int'(a) >> 2) + n) % DEPTH;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // One burst: request at current negedge, random stalls, random request noise.
  task automatic burst(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] len,
                       input int stall_pct, input int idle);
    int beat;
    logic prev_stall;
    logic [DATA_W-1:0] prev_data;
    for (int i = 0; i < idle; i++) begin
      check("R2 idle r_valid", r_valid, 0);
      @(posedge clk); @(negedge clk);
    end
    check("R1 ar_ready idle", ar_ready, 1);
    ar_valid = 1'b1; ar_addr = a; ar_len = len;
    @(posedge clk); @(negedge clk);
    check("R2 r_valid after accept", r_valid, 1);
    beat = 0;
    prev_stall = 1'b0;
    prev_data = '0;
    while (beat <= int'(len)) begin
      check("R4 beat data", r_data, exp_word(exp_idx(a, beat)));
      check("R5 last flag", r_last, (beat == int'(len)));
      check("R7 resp okay", r_resp, 0);
      check("R6 ar_ready low busy", ar_ready, 0);
      if (prev_stall) check("R3 held data", r_data, prev_data);
      prev_data = r_data;
      r_ready = (($urandom % 100) >= stall_pct);
      prev_stall = !r_ready;
      ar_valid = $urandom % 2;
      ar_addr = ADDR_W'($urandom);
      ar_len = LEN_W'($urandom);
      @(posedge clk); @(negedge clk);
      if (prev_stall) check("R3 held valid", r_valid, 1);
      if (r_ready) beat++;
    end
    ar_valid = 1'b0;
    r_ready = 1'b0;
    check("R6 ar_ready back", ar_ready, 1);
    check("R6 r_valid done", r_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #3;
    check("R8 r_valid in reset", r_valid, 0);
    check("R8 ar_ready in reset", ar_ready, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 ar_ready after reset", ar_ready, 1);
    check("R2 no data after reset", r_valid, 0);

    burst(10'h000, 4'd0, 0, 0);        // single beat
    burst(10'h040, 4'd15, 0, 0);       // longest, no stall, back to back
    burst(10'h0F8, 4'd5, 50, 1);       // wraps index 62,63,0,...
    burst(10'h3FC, 4'd3, 70, 2);       // top address, heavy stall
    burst(10'h123, 4'd7, 90, 0);       // unaligned address bits ignored
    for (int t = 0; t < 40; t++)
      burst(ADDR_W'($urandom), LEN_W'($urandom), $urandom % 80, $urandom % 3);

    // Reset in the middle of a burst.
    ar_valid = 1'b1; ar_addr = 10'h010; ar_len = 4'd9;
    @(posedge clk); @(negedge clk);
    ar_valid = 1'b0;
    r_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 busy before reset", r_valid, 1);
    rst_n = 1'b0;
    #1;
    check("R8 r_valid cleared", r_valid, 0);
    check("R8 ar_ready set", ar_ready, 1);
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    r_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 idle after reset", r_valid, 0);
    burst(10'h020, 4'd2, 30, 0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

endmodule